// File: doc/BRIEF.md
# Sensor Trigger Throttler and Associator

This block sits between the central trigger source and a set of pixel sensors. Physics triggers and heartbeat triggers reach it as single-cycle pulses, each carrying a bunch-crossing number and an orbit number. The block forwards a trigger to the sensors only when enough time has passed since the last sensor trigger. A trigger that comes too soon is not forwarded. Its timestamp is instead attached to the sensor event that is already open, so no central trigger is ever lost from the record.

Each forwarded trigger opens a sensor event in an in-order queue. The event holds the list of central triggers merged into it and a busy bit. The busy bit collects the sensor busy level while the event is the newest open one. The sensor side signals the end of each returned data frame with a one-cycle `frame_done` pulse. That pulse closes the oldest open event. Closed events leave in issue order on a valid/ready output stream, which presents the trigger list, its length and the busy bit.

Back-pressure rules: the trigger input has no ready signal, and a record that cannot be stored is dropped and flagged. On the output stream, `out_valid` stays high and every output field holds its value until the cycle in which `out_ready` is high. One event leaves per handshake cycle. `out_ready` may change in any cycle.

Top module: `trg_throttle_assoc`

## Requirements
- R1: A trigger is forwarded when more than `WINDOW` cycles have passed since the last forwarded trigger, and always for the first trigger after reset. `sens_trig` is a one-cycle pulse that follows the accepting `trg_valid` cycle by one clock. The gap between two `sens_trig` pulses is therefore always greater than `WINDOW`.
- R2: A trigger that arrives `WINDOW` or fewer cycles after the last forwarded one produces no `sens_trig` pulse. It is appended to the newest open event. A distance of exactly `WINDOW` cycles counts as a merge.
- R3: Every stored trigger keeps its heartbeat flag, bunch crossing and orbit, in arrival order. Slot j of an event appears on `out_hb[j]`, `out_bc[j*12 +: 12]` and `out_orbit[j*32 +: 32]`, and slot 0 is the trigger that opened the event.
- R4: The busy bit of an event is the OR of `sensor_busy`, sampled at every clock edge after the edge that created the event. Sampling stops at the edge that creates the next event or at the edge that closes this event.
- R5: `frame_done` closes the oldest event that is not yet closed. Only closed events are offered on the output, in the order they were opened. A `frame_done` with no open event has no effect.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_count`, `out_busy` and all slot fields keep their values. An event is removed in a cycle where both are high.
- R7: The queue holds `EV_DEPTH` events (8). A trigger that would be forwarded while the queue is full is dropped: there is no `sens_trig` pulse, nothing is stored and `err_overflow` is set.
- R8: An event holds `MAX_TRIG` triggers (4). A trigger to be merged is dropped and `err_overflow` is set if the newest event is full, is already closed, or does not exist.
- R9: `err_overflow` stays high from the cycle after it is set until reset.
- R10: `out_count` equals the number of triggers stored in the presented event (1 to `MAX_TRIG`). Slots at or above `out_count` read as zero.
- R11: After reset `sens_trig`, `out_valid` and `err_overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz in the system) |
| rst_n | input | 1 | Active-low synchronous reset |
| trg_valid | input | 1 | One-cycle pulse marking an incoming central trigger |
| trg_heartbeat | input | 1 | 1 = heartbeat trigger, 0 = physics trigger |
| trg_bc | input | 12 | Bunch-crossing number of the trigger |
| trg_orbit | input | 32 | Orbit number of the trigger |
| sensor_busy | input | 1 | Busy level reported by the sensors |
| frame_done | input | 1 | One-cycle pulse: sensors finished returning a data frame |
| sens_trig | output | 1 | One-cycle trigger pulse to the sensors |
| out_valid | output | 1 | A closed event is presented |
| out_ready | input | 1 | Consumer accepts the presented event |
| out_count | output | 3 | Number of triggers in the presented event |
| out_busy | output | 1 | Busy bit of the presented event |
| out_hb | output | 4 | Heartbeat flag per slot |
| out_bc | output | 48 | Bunch crossing per slot, 12 bits each |
| out_orbit | output | 128 | Orbit per slot, 32 bits each |
| err_overflow | output | 1 | Sticky flag: a trigger record was dropped |

## Verification
The assertions assume that `trg_valid` and `frame_done` are synchronous to `clk` and that `WINDOW` is at least 1. They do not assume that a trigger and a frame completion are never in the same cycle, or that `frame_done` only comes with an open event. Both cases are legal and are handled by R5 and R8. The bench changes every input at the falling edge and holds each pulse for exactly one cycle. It spaces triggers so that every spacing case lies at a known distance from the window: one cycle, exactly `WINDOW`, and `WINDOW`+1. It holds `out_ready` low for several cycles while an event is presented, so the stream stability rule is exercised.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int BC_W  = 12;
  localparam int ORB_W = 32;

  typedef struct packed {
    logic             hb;
    logic [BC_W-1:0]  bc;
    logic [ORB_W-1:0] orbit;
  } trig_rec_t;
endpackage

// File: rtl/trg_spacing_timer.sv
module trg_spacing_timer #(
  parameter int WINDOW = 40
)(
  input  logic clk,
  input  logic rst_n,
  input  logic trg_valid,
  input  logic queue_full,
  output logic issue,
  output logic merge_req,
  output logic fwd_blocked,
  output logic sens_trig
);
  localparam int SW = $clog2(WINDOW + 2);
  localparam logic [SW-1:0] WIN_L = SW'(WINDOW);
  localparam logic [SW-1:0] SAT   = SW'(WINDOW + 1);

  logic [SW-1:0] since;
  logic          fwd_cand;

  assign fwd_cand    = trg_valid && (since > WIN_L);
  assign issue       = fwd_cand && !queue_full;
  assign fwd_blocked = fwd_cand && queue_full;
  assign merge_req   = trg_valid && !fwd_cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since     <= SAT;
      sens_trig <= 1'b0;
    end else begin
      sens_trig <= issue;
      if (issue)
        since <= SW'(1);
      else if (since < SAT)
        since <= since + 1'b1;
    end
  end

  AST_SENS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sens_trig |=> !sens_trig); // R1

  AST_BLOCK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_blocked |=> !sens_trig); // R7
endmodule

// File: rtl/trg_event_queue.sv
module trg_event_queue import trg_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int MAXT  = 4,
  localparam int TCW  = $clog2(MAXT + 1)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic                   merge_try,
  input  trig_rec_t              rec_in,
  input  logic                   sensor_busy,
  input  logic                   frame_done,
  input  logic                   pop_ready,
  output logic                   full,
  output logic                   merge_drop,
  output logic                   head_valid,
  output logic [TCW-1:0]         head_cnt,
  output logic                   head_busy,
  output trig_rec_t [MAXT-1:0]   head_recs
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]  LAST  = PW'(DEPTH - 1);
  localparam logic [OW-1:0]  DEP_L = OW'(DEPTH);
  localparam logic [TCW-1:0] MAX_L = TCW'(MAXT);

  trig_rec_t [MAXT-1:0] slots [DEPTH];
  logic [TCW-1:0]       tcnt  [DEPTH];
  logic [DEPTH-1:0]     busy_q;
  logic [PW-1:0]        wr_ptr, rd_ptr, newest;
  logic [OW-1:0]        occ, done_cnt;
  logic                 newest_open, merge_ok, fire, done_inc, cap;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign newest      = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  assign full        = (occ == DEP_L);
  assign newest_open = (occ != '0) && (done_cnt < occ);
  assign merge_ok    = merge_try && newest_open && (tcnt[newest] < MAX_L);
  assign merge_drop  = merge_try && !merge_ok;
  assign head_valid  = (done_cnt != '0);
  assign fire        = head_valid && pop_ready;
  assign done_inc    = frame_done && (done_cnt < occ);
  assign cap         = newest_open && !push;

  assign head_cnt  = tcnt[rd_ptr];
  assign head_busy = busy_q[rd_ptr];
  assign head_recs = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      occ      <= '0;
      done_cnt <= '0;
      busy_q   <= '0;
      for (int i = 0; i < DEPTH; i++) tcnt[i] <= '0;
    end else begin
      occ      <= occ + OW'(push) - OW'(fire);
      done_cnt <= done_cnt + OW'(done_inc) - OW'(fire);
      if (push) begin
        wr_ptr         <= step(wr_ptr);
        tcnt[wr_ptr]   <= TCW'(1);
        busy_q[wr_ptr] <= 1'b0;
      end else if (merge_ok) begin
        tcnt[newest] <= tcnt[newest] + 1'b1;
      end
      if (cap)
        busy_q[newest] <= busy_q[newest] | sensor_busy;
      if (fire)
        rd_ptr <= step(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slots[wr_ptr][0] <= rec_in;
    end else if (merge_ok) begin
      for (int j = 1; j < MAXT; j++)
        if (tcnt[newest] == TCW'(j)) slots[newest][j] <= rec_in;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEP_L); // R7

  AST_DONE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_cnt <= occ); // R5

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid && !pop_ready |=> head_valid && $stable(head_cnt)
      && $stable(head_busy) && $stable(head_recs)); // R6

  AST_MERGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    merge_ok |=> tcnt[$past(newest)] <= MAX_L); // R8
endmodule

// File: rtl/trg_out_format.sv
module trg_out_format import trg_pkg::*; #(
  parameter int MAXT = 4,
  localparam int TCW = $clog2(MAXT + 1)
)(
  input  trig_rec_t [MAXT-1:0]   recs,
  input  logic [TCW-1:0]         cnt,
  output logic [MAXT-1:0]        hb,
  output logic [MAXT*BC_W-1:0]   bc,
  output logic [MAXT*ORB_W-1:0]  orbit
);
  for (genvar j = 0; j < MAXT; j++) begin : g_slot
    logic used;
    assign used                     = (cnt > TCW'(j));
    assign hb[j]                    = used & recs[j].hb;
    assign bc[j*BC_W +: BC_W]       = used ? recs[j].bc    : '0;
    assign orbit[j*ORB_W +: ORB_W]  = used ? recs[j].orbit : '0;
  end
endmodule

// File: rtl/trg_throttle_assoc.sv
module trg_throttle_assoc import trg_pkg::*; #(
  parameter int WINDOW   = 40,
  parameter int EV_DEPTH = 8,
  parameter int MAX_TRIG = 4,
  localparam int TCW     = $clog2(MAX_TRIG + 1)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trg_valid,
  input  logic                      trg_heartbeat,
  input  logic [BC_W-1:0]           trg_bc,
  input  logic [ORB_W-1:0]          trg_orbit,
  input  logic                      sensor_busy,
  input  logic                      frame_done,
  output logic                      sens_trig,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [TCW-1:0]            out_count,
  output logic                      out_busy,
  output logic [MAX_TRIG-1:0]       out_hb,
  output logic [MAX_TRIG*BC_W-1:0]  out_bc,
  output logic [MAX_TRIG*ORB_W-1:0] out_orbit,
  output logic                      err_overflow
);
  localparam int GW = $clog2(WINDOW + 2);
  localparam logic [GW-1:0] GSAT = GW'(WINDOW + 1);
  localparam logic [GW-1:0] GWIN = GW'(WINDOW);

  trig_rec_t                rec;
  trig_rec_t [MAX_TRIG-1:0] head_recs;
  logic issue, merge_req, fwd_blocked, q_full, merge_drop;

  assign rec = '{hb: trg_heartbeat, bc: trg_bc, orbit: trg_orbit};

  trg_spacing_timer #(.WINDOW(WINDOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .trg_valid(trg_valid), .queue_full(q_full),
    .issue(issue), .merge_req(merge_req), .fwd_blocked(fwd_blocked),
    .sens_trig(sens_trig)
  );

  trg_event_queue #(.DEPTH(EV_DEPTH), .MAXT(MAX_TRIG)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(issue), .merge_try(merge_req),
    .rec_in(rec), .sensor_busy(sensor_busy), .frame_done(frame_done),
    .pop_ready(out_ready), .full(q_full), .merge_drop(merge_drop),
    .head_valid(out_valid), .head_cnt(out_count), .head_busy(out_busy),
    .head_recs(head_recs)
  );

  trg_out_format #(.MAXT(MAX_TRIG)) u_fmt (
    .recs(head_recs), .cnt(out_count),
    .hb(out_hb), .bc(out_bc), .orbit(out_orbit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_overflow <= 1'b0;
    else if (fwd_blocked || merge_drop) err_overflow <= 1'b1;
  end

  // independent pulse-distance counter for the spacing check
  logic [GW-1:0] chk_gap;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_gap <= GSAT;
    else if (sens_trig) chk_gap <= GW'(1);
    else if (chk_gap < GSAT) chk_gap <= chk_gap + 1'b1;
  end

  AST_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sens_trig |-> chk_gap > GWIN); // R1

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow); // R9

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count != '0) && (out_count <= TCW'(MAX_TRIG))); // R10

  AST_MERGE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    merge_req |=> !sens_trig); // R2
endmodule

// File: tb/tb_trg_throttle_assoc.sv
`timescale 1ns/1ps
module tb_trg_throttle_assoc;
  localparam int WINDOW = 40;
  localparam int NV     = 9;

  typedef struct packed {
    logic [7:0]  gap;
    logic        hb;
    logic [11:0] bc;
    logic [31:0] orbit;
    logic [1:0]  code;   // 1 = new event, 0 = merge, 2 = dropped
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{8'd5,  1'b0, 12'h101, 32'h10, 2'd1},
    '{8'd10, 1'b1, 12'h102, 32'h11, 2'd0},
    '{8'd30, 1'b0, 12'h103, 32'h12, 2'd0},
    '{8'd1,  1'b0, 12'h104, 32'h13, 2'd1},
    '{8'd41, 1'b1, 12'h105, 32'h14, 2'd1},
    '{8'd3,  1'b0, 12'h106, 32'h15, 2'd0},
    '{8'd3,  1'b0, 12'h107, 32'h16, 2'd0},
    '{8'd3,  1'b1, 12'h108, 32'h17, 2'd0},
    '{8'd3,  1'b0, 12'h109, 32'h18, 2'd2}
  };

  logic clk = 0, rst_n = 0;
  logic trg_valid = 0, trg_heartbeat = 0, sensor_busy = 0, frame_done = 0, out_ready = 0;
  logic [11:0] trg_bc = 0;
  logic [31:0] trg_orbit = 0;
  logic sens_trig, out_valid, out_busy, err_overflow;
  logic [2:0] out_count;
  logic [3:0] out_hb;
  logic [47:0] out_bc;
  logic [127:0] out_orbit;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  trg_throttle_assoc #(.WINDOW(WINDOW), .EV_DEPTH(8), .MAX_TRIG(4)) dut (
    .clk(clk), .rst_n(rst_n), .trg_valid(trg_valid), .trg_heartbeat(trg_heartbeat),
    .trg_bc(trg_bc), .trg_orbit(trg_orbit), .sensor_busy(sensor_busy),
    .frame_done(frame_done), .sens_trig(sens_trig), .out_valid(out_valid),
    .out_ready(out_ready), .out_count(out_count), .out_busy(out_busy),
    .out_hb(out_hb), .out_bc(out_bc), .out_orbit(out_orbit),
    .err_overflow(err_overflow)
  );

  task automatic ck(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; trg_valid = 0; frame_done = 0; out_ready = 0; sensor_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send(input int gap, input bit hb, input logic [11:0] bc,
                      input logic [31:0] orb, output bit pulse);
    repeat (gap - 1) @(negedge clk);
    trg_valid = 1; trg_heartbeat = hb; trg_bc = bc; trg_orbit = orb;
    @(negedge clk);
    trg_valid = 0;
    pulse = sens_trig;
  endtask

  task automatic done_pulse();
    frame_done = 1;
    @(negedge clk);
    frame_done = 0;
    @(negedge clk);
  endtask

  task automatic pop();
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    #2000000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int          e_cnt [3];
    logic [11:0] e_bc  [3][4];
    logic [31:0] e_orb [3][4];
    bit          e_hb  [3][4];
    bit          e_busy[3];
    int          ev;
    bit          p;

    e_busy = '{1'b0, 1'b0, 1'b1};
    ev = -1;
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].code == 2'd1) begin ev++; e_cnt[ev] = 0; end
      if (TBL[i].code != 2'd2) begin
        e_bc[ev][e_cnt[ev]]  = TBL[i].bc;
        e_orb[ev][e_cnt[ev]] = TBL[i].orbit;
        e_hb[ev][e_cnt[ev]]  = TBL[i].hb;
        e_cnt[ev]++;
      end
    end

    // R11 reset state
    do_reset();
    ck("R11 sens_trig", sens_trig, 0);
    ck("R11 out_valid", out_valid, 0);
    ck("R11 err_overflow", err_overflow, 0);

    // table walk: R1 forward, R2 merge (incl. exactly WINDOW), R8 list full
    for (int i = 0; i < NV; i++) begin
      send(TBL[i].gap, TBL[i].hb, TBL[i].bc, TBL[i].orbit, p);
      if (TBL[i].code == 2'd1)      ck("R1 forwarded pulse", p, 1);
      else if (TBL[i].code == 2'd0) ck("R2 merged no pulse", p, 0);
      else                          ck("R8 list full no pulse", p, 0);
      if (i == 4) sensor_busy = 1;
      if (i == 5) sensor_busy = 0;
    end
    ck("R8 err after list overflow", err_overflow, 1);
    ck("R5 nothing closed yet", out_valid, 0);

    for (int i = 0; i < 3; i++) done_pulse();
    ck("R5 closed event offered", out_valid, 1);
    ck("R6 count before stall", out_count, e_cnt[0]);
    repeat (4) @(negedge clk);
    ck("R6 valid held", out_valid, 1);
    ck("R6 count held", out_count, e_cnt[0]);
    ck("R6 bc held", out_bc[11:0], e_bc[0][0]);

    for (int e = 0; e < 3; e++) begin
      ck("R5 valid in order", out_valid, 1);
      ck("R10 count", out_count, e_cnt[e]);
      ck("R4 busy bit", out_busy, e_busy[e]);
      for (int j = 0; j < 4; j++) begin
        if (j < e_cnt[e]) begin
          ck("R3 slot bc", out_bc[j*12 +: 12], e_bc[e][j]);
          ck("R3 slot orbit", out_orbit[j*32 +: 32], e_orb[e][j]);
          ck("R3 slot hb", out_hb[j], e_hb[e][j]);
        end else begin
          ck("R10 unused bc zero", out_bc[j*12 +: 12], 0);
          ck("R10 unused orbit zero", out_orbit[j*32 +: 32], 0);
          ck("R10 unused hb zero", out_hb[j], 0);
        end
      end
      pop();
    end
    ck("R6 drained", out_valid, 0);
    ck("R9 err still set", err_overflow, 1);

    // directed: stray frame_done, merge into closed event, stickiness
    do_reset();
    ck("R11 err cleared by reset", err_overflow, 0);
    done_pulse();
    send(1, 1'b0, 12'h0AA, 32'hA0, p);
    ck("R1 first after reset", p, 1);
    repeat (2) @(negedge clk);
    ck("R5 stray frame_done ignored", out_valid, 0);
    done_pulse();
    ck("R5 frame_done closes", out_valid, 1);
    ck("R5 count one", out_count, 1);
    send(1, 1'b0, 12'h0BB, 32'hB0, p);
    ck("R8 merge into closed no pulse", p, 0);
    @(negedge clk);
    ck("R8 err on closed merge", err_overflow, 1);
    ck("R8 closed list unchanged", out_count, 1);
    ck("R8 closed slot1 empty", out_bc[23:12], 0);
    repeat (50) @(negedge clk);
    ck("R9 err sticky", err_overflow, 1);
    pop();
    ck("R5 queue empty", out_valid, 0);

    // directed: event queue full
    do_reset();
    for (int k = 0; k < 9; k++) begin
      send((k == 0) ? 1 : WINDOW + 1, 1'b0, 12'(k), 32'(k), p);
      ck("R7 pulse while room", p, (k < 8) ? 1 : 0);
    end
    @(negedge clk);
    ck("R7 err on full queue", err_overflow, 1);
    for (int k = 0; k < 9; k++) done_pulse();
    for (int k = 0; k < 8; k++) begin
      ck("R5 in-order valid", out_valid, 1);
      ck("R5 in-order bc", out_bc[11:0], k);
      pop();
    end
    ck("R7 ninth not stored", out_valid, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule